// File: doc/BRIEF.md
# Programmable Interrupt Aggregator

This block collects up to 32 interrupt request lines into a single processor interrupt. Each line is fixed at elaboration as edge-triggered or level-sensitive. Requests are captured into a status register, filtered by a per-line enable register, and the lowest-numbered request that survives the filter is reported through a vector register. A two-bit master control register gates the final interrupt output.

Software drives the block through a small synchronous register port: a word address, write data, a write strobe and combinational read data. Enable bits can be rewritten whole, or changed bit by bit through set and clear aliases, so that two handlers never need a read-modify-write sequence. Captured requests are retired by writing ones to an acknowledge register. A level line that is still high is captured again, so software acknowledges it only after the source has been serviced.

Top module: `irq_hub`

## Requirements
- R1: After reset, status, enable and master control read 0, the vector reads 0xFFFFFFFF and `irq_o` is low.
- R2: A rising edge on an edge-triggered line sets its status bit three clock edges after the line changes. A line held high sets it only once, so after an acknowledge the bit stays clear.
- R3: A level-sensitive line sets its status bit while it is high. An acknowledge while the line is high leaves the bit set. An acknowledge after the line has been low for two edges clears it.
- R4: Writing a mask to offset 0x0C clears the matching status bits and leaves bits written 0 unchanged. If a new edge arrives in the same cycle as its acknowledge, the status bit stays set.
- R5: A write to offset 0x08 replaces the enable register. Reading offset 0x08 returns it.
- R6: Writing a mask to offset 0x10 sets those enable bits. Writing a mask to offset 0x14 clears those enable bits. Bits written 0 are unchanged in both cases.
- R7: Offset 0x04 reads status AND enable. Writes to offsets 0x00, 0x04 and 0x18 change no state.
- R8: Offset 0x18 reads the index of the lowest-numbered bit set in status AND enable. It reads 0xFFFFFFFF when no such bit exists.
- R9: Offset 0x1C holds master control. Bit 0 is the global enable and bit 1 is the output enable, and the upper bits read 0. `irq_o` is high only when both bits are 1 and status AND enable is nonzero.
- R10: Lines at or above `NUM_SRC` never set status. Their status and enable bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 3 | Word address, byte address bits [4:2] |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one write per cycle while high |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| src_i | input | 32 | Interrupt request lines |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
A register write takes effect at the clock edge that samples the strobe. Reads, the vector and `irq_o` follow the registers within the same cycle. A change on a request line reaches status at the third rising edge after the change: two synchronizer stages, then the capture. The driver changes inputs only at falling edges, and the scoreboard monitor samples 1 ns after the falling edge at which each read is set up. Every expected value therefore refers to a known number of elapsed rising edges. The bench also checks status one edge before the capture is due, and places an acknowledge exactly on the edge where a new rising edge is captured.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;

    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_SETEN  = 3'd4,
        SEL_CLREN  = 3'd5,
        SEL_VECTOR = 3'd6,
        SEL_MASTER = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] enable;
        logic [1:0]       master;
    } ctrl_state_t;

    typedef struct packed {
        logic [REG_W-1:0] sync1;
        logic [REG_W-1:0] sync2;
        logic [REG_W-1:0] prev;
    } sync_state_t;

    // Mask of the implemented request lines.
    function automatic logic [REG_W-1:0] line_mask(input int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_hub_detect.sv
`timescale 1ns/1ps
module irq_hub_detect
    import irq_hub_pkg::*;
#(
    parameter int               NUM_SRC  = 8,
    parameter logic [REG_W-1:0] SRC_KIND = 32'h0000_000F
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [REG_W-1:0] src_i,
    output logic [REG_W-1:0] req_o
);

    localparam logic [REG_W-1:0] VALID     = line_mask(NUM_SRC);
    localparam logic [REG_W-1:0] EDGE_MASK = SRC_KIND & VALID;
    localparam logic [REG_W-1:0] LVL_MASK  = ~SRC_KIND & VALID;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = src_i & VALID;
        st_d.sync2 = st_q.sync1;
        st_d.prev  = st_q.sync2;
        req_o      = (EDGE_MASK & st_q.sync2 & ~st_q.prev)
                   | (LVL_MASK & st_q.sync2);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    // An edge line asks for capture for a single cycle only.
    AST_EDGE_ONE_SHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((req_o & $past(req_o) & EDGE_MASK) == '0)); // R2

    // A level line keeps asking while its synchronized sample stays high.
    AST_LEVEL_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((($past(req_o) & st_q.sync2 & LVL_MASK) & ~req_o) == '0)); // R3

endmodule

// File: rtl/irq_hub_regs.sv
`timescale 1ns/1ps
module irq_hub_regs
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_i,
    input  reg_sel_e         sel_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [REG_W-1:0] req_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] enable_o,
    output logic [1:0]       master_o
);

    localparam logic [REG_W-1:0] VALID = line_mask(NUM_SRC);

    ctrl_state_t st_d, st_q;
    logic [REG_W-1:0] ack_mask;

    always_comb begin
        st_d     = st_q;
        ack_mask = '0;
        if (wr_i && sel_i == SEL_ACK) ack_mask = wdata_i;
        // A request in the same cycle as its acknowledge wins.
        st_d.status = ((st_q.status & ~ack_mask) | req_i) & VALID;
        if (wr_i) begin
            unique case (sel_i)
                SEL_ENABLE: st_d.enable = wdata_i & VALID;
                SEL_SETEN:  st_d.enable = (st_q.enable | wdata_i) & VALID;
                SEL_CLREN:  st_d.enable = st_q.enable & ~wdata_i;
                SEL_MASTER: st_d.master = wdata_i[1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign enable_o = st_q.enable;
    assign master_o = st_q.master;

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && sel_i == SEL_ACK) |=>
            ((st_q.status & $past(wdata_i) & ~$past(req_i)) == '0)); // R4

    AST_STATUS_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((st_q.status & ~$past(st_q.status) & ~$past(req_i)) == '0)); // R2

    AST_SETEN_KEEPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && sel_i == SEL_SETEN) |=>
            ((st_q.enable & $past(st_q.enable)) == $past(st_q.enable))); // R6

    AST_CLREN_KEEPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && sel_i == SEL_CLREN) |=>
            ((st_q.enable & ~$past(st_q.enable)) == '0)); // R6

    AST_STATUS_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        ((st_q.status | st_q.enable) & ~VALID) == '0); // R10

endmodule

// File: rtl/irq_hub_prio.sv
`timescale 1ns/1ps
module irq_hub_prio
    import irq_hub_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [REG_W-1:0] pend_i,
    output logic             found_o,
    output logic [4:0]       index_o
);

    // Scan from the top so the lowest set bit is assigned last.
    always_comb begin
        found_o = 1'b0;
        index_o = '0;
        for (int i = REG_W - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                index_o = 5'(i);
            end
        end
    end

    AST_VEC_IS_PENDING: assert property (@(posedge clk_i) disable iff (rst_i)
        found_o |-> pend_i[index_o]); // R8

    AST_VEC_IS_LOWEST: assert property (@(posedge clk_i) disable iff (rst_i)
        found_o |-> ((pend_i & ((32'd1 << index_o) - 32'd1)) == '0)); // R8

    AST_NONE_FOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        !found_o |-> (pend_i == '0)); // R8

endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int               NUM_SRC  = 8,
    parameter logic [REG_W-1:0] SRC_KIND = 32'h0000_000F
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [4:2]       addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             wr_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic [REG_W-1:0] src_i,
    output logic             irq_o
);

    reg_sel_e         sel;
    logic [REG_W-1:0] req;
    logic [REG_W-1:0] status, enable, pending;
    logic [1:0]       master;
    logic             found;
    logic [4:0]       index;

    assign sel = reg_sel_e'(addr_i);

    irq_hub_detect #(.NUM_SRC(NUM_SRC), .SRC_KIND(SRC_KIND)) detect_i (
        .clk_i(clk_i), .rst_i(rst_i), .src_i(src_i), .req_o(req)
    );

    irq_hub_regs #(.NUM_SRC(NUM_SRC)) regs_i (
        .clk_i(clk_i), .rst_i(rst_i), .wr_i(wr_i), .sel_i(sel),
        .wdata_i(wdata_i), .req_i(req),
        .status_o(status), .enable_o(enable), .master_o(master)
    );

    assign pending = status & enable;

    irq_hub_prio prio_i (
        .clk_i(clk_i), .rst_i(rst_i), .pend_i(pending),
        .found_o(found), .index_o(index)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: rdata_o = status;
            SEL_PEND:   rdata_o = pending;
            SEL_ENABLE: rdata_o = enable;
            SEL_VECTOR: rdata_o = found ? {27'd0, index} : '1;
            SEL_MASTER: rdata_o = {30'd0, master};
            default:    rdata_o = '0;
        endcase
    end

    assign irq_o = (master == 2'b11) && found;

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> ((status & enable) != '0)); // R9

    AST_IRQ_MASTER_GATE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!master[0] || !master[1]) |-> !irq_o); // R9

endmodule

// File: tb/irq_hub_tb_top.sv
`timescale 1ns/1ps
module irq_hub_tb_top;

    localparam logic [4:0] O_STATUS = 5'h00, O_PEND = 5'h04, O_ENABLE = 5'h08,
                           O_ACK = 5'h0C, O_SETEN = 5'h10, O_CLREN = 5'h14,
                           O_VECTOR = 5'h18, O_MASTER = 5'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:2]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic [31:0] rdata;
    logic [31:0] src = '0;
    logic        irq;

    always #2.5 clk = ~clk;

    irq_hub #(.NUM_SRC(8), .SRC_KIND(32'h0000_000F)) dut_i (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
        .rdata_o(rdata), .src_i(src), .irq_o(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t q[$];
    event smp_ev;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        addr = a[4:2];
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        ->smp_ev;
    endtask

    task automatic irq_chk(input bit e, input string tag);
        exp_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        q.push_back(it);
        ->smp_ev;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a[4:2]; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(smp_ev);
            #1;
            while (q.size() > 0) begin
                exp_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_irq ? {31'd0, irq} : rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        rd_chk(O_STATUS, 32'h0, "R1 status");
        rd_chk(O_ENABLE, 32'h0, "R1 enable");
        rd_chk(O_MASTER, 32'h0, "R1 master");
        rd_chk(O_VECTOR, 32'hFFFF_FFFF, "R1 vector");
        irq_chk(1'b0, "R1 irq");
        // R5 whole write, R10 upper enable bits
        wr_reg(O_ENABLE, 32'hFFFF_FFFF);
        rd_chk(O_ENABLE, 32'h0000_00FF, "R5 R10 enable write");
        wr_reg(O_ENABLE, 32'h0);
        // R6 set / clear aliases
        wr_reg(O_SETEN, 32'h05);
        rd_chk(O_ENABLE, 32'h05, "R6 set");
        wr_reg(O_SETEN, 32'h02);
        rd_chk(O_ENABLE, 32'h07, "R6 set keeps");
        wr_reg(O_CLREN, 32'h04);
        rd_chk(O_ENABLE, 32'h03, "R6 clear");
        // R2 edge capture latency
        set_src(32'h01);
        idle(1);
        rd_chk(O_STATUS, 32'h0, "R2 not yet");
        rd_chk(O_STATUS, 32'h1, "R2 captured");
        rd_chk(O_PEND, 32'h1, "R7 pending");
        rd_chk(O_VECTOR, 32'h0, "R8 vector 0");
        // R7 read-only offsets
        wr_reg(O_STATUS, 32'h0);
        wr_reg(O_PEND, 32'h0);
        wr_reg(O_VECTOR, 32'hFF);
        rd_chk(O_STATUS, 32'h1, "R7 status unchanged");
        rd_chk(O_ENABLE, 32'h03, "R7 enable unchanged");
        // R9 master gating
        irq_chk(1'b0, "R9 master off");
        wr_reg(O_MASTER, 32'h1);
        irq_chk(1'b0, "R9 only bit0");
        wr_reg(O_MASTER, 32'h2);
        irq_chk(1'b0, "R9 only bit1");
        wr_reg(O_MASTER, 32'hFFFF_FFFF);
        rd_chk(O_MASTER, 32'h3, "R9 upper bits");
        irq_chk(1'b1, "R9 both set");
        // R2 held edge line does not re-capture
        wr_reg(O_ACK, 32'h1);
        idle(3);
        rd_chk(O_STATUS, 32'h0, "R2 held no recapture");
        irq_chk(1'b0, "R9 nothing pending");
        rd_chk(O_VECTOR, 32'hFFFF_FFFF, "R8 none");
        // R3 level line
        set_src(32'h11);
        idle(2);
        rd_chk(O_STATUS, 32'h10, "R3 level captured");
        rd_chk(O_PEND, 32'h0, "R7 disabled not pending");
        wr_reg(O_SETEN, 32'h10);
        irq_chk(1'b1, "R9 level irq");
        rd_chk(O_VECTOR, 32'h4, "R8 vector 4");
        wr_reg(O_ACK, 32'h10);
        rd_chk(O_STATUS, 32'h10, "R3 ack while high");
        set_src(32'h01);
        idle(3);
        wr_reg(O_ACK, 32'h10);
        rd_chk(O_STATUS, 32'h0, "R3 ack after low");
        irq_chk(1'b0, "R3 irq cleared");
        // R8 priority
        wr_reg(O_ENABLE, 32'h60);
        set_src(32'h61);
        idle(2);
        rd_chk(O_STATUS, 32'h60, "R3 two levels");
        rd_chk(O_VECTOR, 32'h5, "R8 lowest 5");
        wr_reg(O_CLREN, 32'h20);
        rd_chk(O_PEND, 32'h40, "R7 pending masked");
        rd_chk(O_VECTOR, 32'h6, "R8 next 6");
        // R4 selective acknowledge
        set_src(32'h01);
        idle(3);
        wr_reg(O_ACK, 32'h20);
        rd_chk(O_STATUS, 32'h40, "R4 zeros unchanged");
        wr_reg(O_ACK, 32'hFFFF_FFFF);
        rd_chk(O_STATUS, 32'h0, "R4 ack all");
        // R10 lines above NUM_SRC
        wr_reg(O_ENABLE, 32'hFFFF_FFFF);
        set_src(32'hFFFF_FF01);
        idle(4);
        rd_chk(O_STATUS, 32'h0, "R10 upper ignored");
        irq_chk(1'b0, "R10 irq low");
        // R4 edge wins over same-cycle acknowledge
        set_src(32'h0);
        idle(3);
        set_src(32'h1);
        idle(1);
        wr_reg(O_ACK, 32'h1);
        rd_chk(O_STATUS, 32'h1, "R4 edge wins");
        irq_chk(1'b1, "R9 irq on edge");
        wr_reg(O_ACK, 32'h1);
        rd_chk(O_STATUS, 32'h0, "R4 later ack");
        idle(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule